// File: doc/BRIEF.md
# Negative-Angle Intra Reference Array Builder

This block prepares the one-dimensional main reference array that an angular intra predictor walks when a block is predicted from a horizontal-leaning direction with a negative angle (modes 11 through 17). It fetches samples one per clock from an external neighbour buffer through a combinational read port. That buffer holds the left column at the low addresses, the corner sample at address 2*nt and the top row above it. The block places the corner followed by the left column, reversed, at array positions 0..nt.

When the angle is steep enough that the predictor would reach past position 0, the block extends the array into negative positions. For each extra position it advances an inverse-angle accumulator and takes a top-row sample chosen by the accumulator's integer part. A one-cycle completion pulse marks the point where the array is ready. The array is then read combinationally through a signed index, so the interpolation stage can address positions -nt..nt directly.

Top module: `intra_refarr_top`

## Requirements
- R1: After reset `done` and `busy` are low and every array position reads back as 0.
- R2: After a run, array position k holds neighbour sample at address 2*nt - k for every k in 0..nt.
- R3: `nt_sel` encodes the block size: 0 gives nt=4, 1 gives 8, 2 gives 16, 3 gives 32.
- R4: With angles -2, -5, -9, -13, -17, -21, -26 for modes 11..17 and e = (nt*angle) arithmetically shifted right by 5, the run writes (-1 - e) extension positions when e < -1 and none otherwise.
- R5: Extension position -j (j = 1, 2, ...) holds the neighbour sample at address 2*nt + ((128 + j*inv) >> 8), with inverse-angle magnitudes 4096, 1638, 910, 630, 482, 390, 315 for modes 11..17.
- R6: One sample is written per clock. `done` is high for exactly one cycle, nt+1+N clock edges after the edge that accepted `start`, where N is the extension count. `busy` is high from the accepting edge until `done` rises.
- R7: A `start` pulse that arrives while `busy` is high is ignored: timing and contents follow the run already in progress.
- R8: A `start` with `mode` outside 11..17 is ignored: `busy` stays low, no `done` follows and the array keeps its contents.
- R9: `ref_data` shows, without a clock, the array position addressed by the two's-complement `ref_idx`, valid for -nt..nt.
- R10: The first neighbour address presented after a run is accepted is 2*nt, the corner, and `nbr_data` is consumed in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a build when idle and the mode is legal |
| nt_sel | input | 2 | Block size code (4 << nt_sel) |
| mode | input | 5 | Intra mode number, 11..17 accepted |
| nbr_addr | output | 8 | Neighbour buffer read address |
| nbr_data | input | 8 | Neighbour sample at `nbr_addr`, same cycle |
| ref_idx | input | 7 | Signed array position to read |
| ref_data | output | 8 | Array sample at `ref_idx` |
| busy | output | 1 | Build in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong write counter or a wrong address offset corrupts a position the reader sees. It also moves the `done` pulse away from nt+1+N edges, so a single finished run shows it at the ports. A wrong angle or shift in the count logic changes the latency and leaves negative positions wrong, while a bad accumulator start or step shows only in the extension samples. Each vector therefore compares both the latency and every position from -N to nt. A configuration latched again in the middle of a run would change the latency and the contents of that same run.

// File: rtl/intra_ref_pkg.sv
package intra_ref_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_COPY = 2'd1,
        PH_EXT  = 2'd2
    } phase_t;

    localparam int INV_W = 13;

    // Prediction angle per mode; unsupported modes return zero.
    function automatic logic signed [5:0] mode_angle(input logic [4:0] m);
        case (m)
            5'd11:   return -6'sd2;
            5'd12:   return -6'sd5;
            5'd13:   return -6'sd9;
            5'd14:   return -6'sd13;
            5'd15:   return -6'sd17;
            5'd16:   return -6'sd21;
            5'd17:   return -6'sd26;
            default: return 6'sd0;
        endcase
    endfunction

    // Inverse-angle magnitude per mode (table position is mode minus 11).
    function automatic logic [INV_W-1:0] mode_inv(input logic [4:0] m);
        case (m)
            5'd11:   return 13'd4096;
            5'd12:   return 13'd1638;
            5'd13:   return 13'd910;
            5'd14:   return 13'd630;
            5'd15:   return 13'd482;
            5'd16:   return 13'd390;
            5'd17:   return 13'd315;
            default: return 13'd0;
        endcase
    endfunction

endpackage

// File: rtl/refarr_lut.sv
module refarr_lut
    import intra_ref_pkg::*;
#(
    parameter int MAX_NT = 32,
    localparam int NT_W  = $clog2(MAX_NT) + 1,
    localparam int PW    = NT_W + 7
) (
    input  logic [NT_W-1:0]  nt_val,
    input  logic [4:0]       mode,
    output logic             mode_ok,
    output logic [INV_W-1:0] inv,
    output logic [NT_W-1:0]  ext_cnt
);

    logic signed [5:0]    ang;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] proj;
    logic [PW-1:0]        cnt_full;

    always_comb begin
        mode_ok  = (mode >= 5'd11) && (mode <= 5'd17);
        ang      = mode_angle(mode);
        inv      = mode_inv(mode);
        prod     = PW'($signed({1'b0, nt_val})) * PW'(ang);
        proj     = prod >>> 5;
        cnt_full = ~proj;  // equals -1 - proj
        // extension only when the projection lies below -1
        ext_cnt  = (proj[PW-1] && (proj != '1)) ? cnt_full[NT_W-1:0] : '0;
    end

endmodule

// File: rtl/refarr_seq.sv
module refarr_seq
    import intra_ref_pkg::*;
#(
    parameter int MAX_NT = 32,
    localparam int NT_W   = $clog2(MAX_NT) + 1,
    localparam int RI_W   = $clog2(MAX_NT) + 2,
    localparam int NBR_AW = $clog2(4 * MAX_NT + 1),
    localparam int ACC_W  = $clog2(MAX_NT) + 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [NT_W-1:0]        nt_req,
    input  logic                   mode_ok,
    input  logic [INV_W-1:0]       inv_req,
    input  logic [NT_W-1:0]        ext_req,
    output logic [NBR_AW-1:0]      nbr_addr,
    output logic                   wr_en,
    output logic signed [RI_W-1:0] wr_idx,
    output logic                   busy,
    output logic                   done
);

    typedef struct packed {
        phase_t           phase;
        logic [NT_W-1:0]  nt;
        logic [NT_W-1:0]  ext;
        logic [INV_W-1:0] inv;
        logic [NT_W-1:0]  k;
        logic [ACC_W-1:0] acc;
        logic             done;
    } st_t;

    st_t st_d, st_q;
    logic [NBR_AW-1:0] corner_addr;

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        nbr_addr    = '0;
        wr_en       = 1'b0;
        wr_idx      = '0;
        corner_addr = NBR_AW'(st_q.nt) << 1;
        case (st_q.phase)
            PH_IDLE: begin
                if (start && mode_ok) begin
                    st_d.phase = PH_COPY;
                    st_d.nt    = nt_req;
                    st_d.ext   = ext_req;
                    st_d.inv   = inv_req;
                    st_d.k     = '0;
                end
            end
            PH_COPY: begin
                // corner first, then the left column walking downwards
                nbr_addr = corner_addr - NBR_AW'(st_q.k);
                wr_en    = 1'b1;
                wr_idx   = RI_W'(st_q.k);
                if (st_q.k == st_q.nt) begin
                    if (st_q.ext != '0) begin
                        st_d.phase = PH_EXT;
                        st_d.k     = NT_W'(1);
                        st_d.acc   = ACC_W'(128) + ACC_W'(st_q.inv);
                    end else begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                    end
                end else begin
                    st_d.k = st_q.k + NT_W'(1);
                end
            end
            PH_EXT: begin
                // projected top-row sample for position -k
                nbr_addr = corner_addr + NBR_AW'(st_q.acc >> 8);
                wr_en    = 1'b1;
                wr_idx   = -RI_W'(st_q.k);
                if (st_q.k == st_q.ext) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.k   = st_q.k + NT_W'(1);
                    st_d.acc = st_q.acc + ACC_W'(st_q.inv);
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = (st_q.phase != PH_IDLE);
    assign done = st_q.done;

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !busy && $past(busy));

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(st_q.nt) && $stable(st_q.ext) && $stable(st_q.inv));

    // R2
    copy_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_COPY) |-> (nbr_addr <= corner_addr) && (nbr_addr >= NBR_AW'(st_q.nt)));

    // R5
    ext_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_EXT) |-> (nbr_addr > corner_addr) && (nbr_addr <= (corner_addr << 1)));

endmodule

// File: rtl/refarr_mem.sv
module refarr_mem #(
    parameter int MAX_NT   = 32,
    parameter int SAMPLE_W = 8,
    localparam int DEPTH   = 2 * MAX_NT + 1,
    localparam int MEM_AW  = $clog2(DEPTH),
    localparam int RI_W    = $clog2(MAX_NT) + 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic signed [RI_W-1:0] wr_idx,
    input  logic [SAMPLE_W-1:0]    wr_data,
    input  logic signed [RI_W-1:0] rd_idx,
    output logic [SAMPLE_W-1:0]    rd_data
);

    logic [SAMPLE_W-1:0] cells_q [DEPTH];
    logic [MEM_AW-1:0]   wr_slot;
    logic [MEM_AW-1:0]   rd_slot;

    // position p is stored at slot p + MAX_NT
    assign wr_slot = MEM_AW'(wr_idx + RI_W'(MAX_NT));
    assign rd_slot = MEM_AW'(rd_idx + RI_W'(MAX_NT));
    assign rd_data = (rd_slot < MEM_AW'(DEPTH)) ? cells_q[rd_slot] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells_q[i] <= '0;
        end else if (wr_en) begin
            cells_q[wr_slot] <= wr_data;
        end
    end

    // R9
    wr_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_slot < MEM_AW'(DEPTH)));

endmodule

// File: rtl/intra_refarr_top.sv
module intra_refarr_top
    import intra_ref_pkg::*;
#(
    parameter int MAX_NT   = 32,
    parameter int SAMPLE_W = 8,
    localparam int MIN_NT  = 4,
    localparam int SEL_W   = $clog2($clog2(MAX_NT) - 1),
    localparam int NT_W    = $clog2(MAX_NT) + 1,
    localparam int RI_W    = $clog2(MAX_NT) + 2,
    localparam int NBR_AW  = $clog2(4 * MAX_NT + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [SEL_W-1:0]       nt_sel,
    input  logic [4:0]             mode,
    output logic [NBR_AW-1:0]      nbr_addr,
    input  logic [SAMPLE_W-1:0]    nbr_data,
    input  logic signed [RI_W-1:0] ref_idx,
    output logic [SAMPLE_W-1:0]    ref_data,
    output logic                   busy,
    output logic                   done
);

    logic [NT_W-1:0]        nt_req;
    logic                   mode_ok;
    logic [INV_W-1:0]       inv_req;
    logic [NT_W-1:0]        ext_req;
    logic                   wr_en;
    logic signed [RI_W-1:0] wr_idx;

    assign nt_req = NT_W'(MIN_NT) << nt_sel;

    refarr_lut #(.MAX_NT(MAX_NT)) u_lut (
        .nt_val  (nt_req),
        .mode    (mode),
        .mode_ok (mode_ok),
        .inv     (inv_req),
        .ext_cnt (ext_req)
    );

    refarr_seq #(.MAX_NT(MAX_NT)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .nt_req   (nt_req),
        .mode_ok  (mode_ok),
        .inv_req  (inv_req),
        .ext_req  (ext_req),
        .nbr_addr (nbr_addr),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .busy     (busy),
        .done     (done)
    );

    refarr_mem #(.MAX_NT(MAX_NT), .SAMPLE_W(SAMPLE_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (nbr_data),
        .rd_idx  (ref_idx),
        .rd_data (ref_data)
    );

endmodule

// File: tb/tb_intra_refarr_top.sv
`timescale 1ns/1ps
module tb_intra_refarr_top;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [1:0]        nt_sel = 2'd0;
    logic [4:0]        mode = 5'd11;
    logic [7:0]        nbr_addr;
    logic [7:0]        nbr_data;
    logic signed [6:0] ref_idx = '0;
    logic [7:0]        ref_data;
    logic              busy;
    logic              done;

    logic [7:0] nbr_mem [129];
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    assign nbr_data = (nbr_addr <= 8'd128) ? nbr_mem[nbr_addr] : 8'h00;

    intra_refarr_top dut (
        .clk(clk), .rst_n(rst_n), .start(start), .nt_sel(nt_sel), .mode(mode),
        .nbr_addr(nbr_addr), .nbr_data(nbr_data), .ref_idx(ref_idx),
        .ref_data(ref_data), .busy(busy), .done(done)
    );

    // {nt_sel, mode, expected extension count} (R3, R4)
    localparam logic [12:0] VECS [10] = '{
        {2'd0, 5'd11, 6'd0},  {2'd0, 5'd17, 6'd3},  {2'd1, 5'd14, 6'd3},
        {2'd1, 5'd12, 6'd1},  {2'd2, 5'd15, 6'd8},  {2'd2, 5'd11, 6'd0},
        {2'd3, 5'd17, 6'd25}, {2'd3, 5'd13, 6'd8},  {2'd3, 5'd11, 6'd1},
        {2'd2, 5'd16, 6'd10}
    };

    function automatic int b_inv(input int m);
        case (m)
            11: return 4096; 12: return 1638; 13: return 910; 14: return 630;
            15: return 482;  16: return 390;  17: return 315; default: return 0;
        endcase
    endfunction

    function automatic int exp_ref(input int pos, input int nt, input int m);
        if (pos >= 0) return int'(nbr_mem[2*nt - pos]);
        return int'(nbr_mem[2*nt + ((128 + (-pos) * b_inv(m)) >> 8)]);
    endfunction

    task automatic fill(input int seed);
        for (int i = 0; i < 129; i++) nbr_mem[i] = 8'((i * 73 + seed * 41 + 17) ^ ((i * 5) >> 3));
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Runs one build; optionally injects a second start at cycle "poke".
    task automatic run(input logic [1:0] s, input logic [4:0] m, input int poke, output int lat);
        @(negedge clk);
        nt_sel = s; mode = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 corner address", int'(nbr_addr), 2 * (4 << s));
        check("R6 busy after accept", int'(busy), 1);
        lat = 0;
        while (!done && lat < 500) begin
            @(negedge clk);
            lat++;
            if (lat == poke) begin start = 1'b1; nt_sel = 2'd3; mode = 5'd17; end
            if (lat == poke + 1) begin start = 1'b0; nt_sel = s; mode = m; end
        end
    endtask

    task automatic verify(input int nt, input int m, input int cnt, input string tag);
        for (int p = -cnt; p <= nt; p++) begin
            ref_idx = 7'(p);
            #0.2;
            check(p >= 0 ? {tag, " R2 copy"} : {tag, " R5 extension"}, int'(ref_data), exp_ref(p, nt, m));
        end
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int lat;
        fill(0);
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 done", int'(done), 0);
        check("R1 busy", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int p = -32; p <= 32; p += 16) begin
            ref_idx = 7'(p);
            #0.2;
            check("R1 array zero", int'(ref_data), 0);
        end

        // Vector table walk: R2 R3 R4 R5 R6 R9 R10
        for (int v = 0; v < 10; v++) begin
            int nt, m, cnt;
            nt  = 4 << VECS[v][12:11];
            m   = int'(VECS[v][10:6]);
            cnt = int'(VECS[v][5:0]);
            fill(v + 1);
            run(VECS[v][12:11], VECS[v][10:6], -5, lat);
            check("R4 R6 latency", lat, nt + 1 + cnt);
            check("R6 busy low at done", int'(busy), 0);
            @(negedge clk);
            check("R6 done single cycle", int'(done), 0);
            verify(nt, m, cnt, "vec");
        end

        // R7: start while busy is ignored
        fill(20);
        run(2'd1, 5'd14, 2, lat);
        check("R7 latency unchanged", lat, 8 + 1 + 3);
        @(negedge clk);
        verify(8, 14, 3, "R7");

        // R8: illegal modes are ignored, array keeps its contents
        for (int t = 0; t < 2; t++) begin
            int seen;
            seen = 0;
            @(negedge clk);
            nt_sel = 2'd3; mode = (t == 0) ? 5'd10 : 5'd18; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int c = 0; c < 40; c++) begin
                if (busy || done) seen = 1;
                @(negedge clk);
            end
            check("R8 no activity", seen, 0);
            ref_idx = 7'sd0;
            #0.2;
            check("R8 contents kept", int'(ref_data), int'(nbr_mem[16]));
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule